// File: doc/BRIEF.md
# Vectored Priority Interrupt Controller

This block sits beside the instruction sequencer of a small processor core. It watches four external request lines, numbered 0 to 3, and raises one request toward the core. Each line has its own mask bit and its own choice of sensing: in level mode the line counts as pending while it is high; in edge mode a rising edge sets a sticky pending latch. Among the unmasked pending lines, the highest-numbered line wins. Its level number is driven out, zero-extended, as the vector address.

The core takes a request by pulsing `int_ack`. That pulse sets the in-service bit of the winning level and clears that level's edge latch. The core pulses `int_rti` on return from a service routine, which clears the highest set in-service bit. A single configuration write loads the mask bits, the edge/level selection and the nesting enable together. With nesting off, nothing new is presented while any level is in service. With nesting on, only a level strictly above the highest in-service level can preempt.

Top module: `vic_irq_ctrl`

## Requirements
- R1: After reset all four mask bits are set, every line is in level mode, nesting is off, `in_service` is 0 and `int_req` stays low whatever the request lines do.
- R2: `int_req` is high exactly when an eligible line exists and the nesting rule allows it. The presented line is the highest-numbered line that is pending and unmasked.
- R3: A line whose mask bit is 1 is never presented. An edge latched while masked stays pending and is presented once the mask bit is cleared.
- R4: A line in level mode (`cfg_edge` bit = 0) is pending in the same cycle its input is high, and stops being pending as soon as its input drops.
- R5: A line in edge mode (`cfg_edge` bit = 1) becomes pending in the cycle after its input rises from 0 to 1. It stays pending after the input falls, until its own level is acknowledged.
- R6: While `int_req` is high, `int_vec` equals the presented level number (0 to 3) with all higher bits 0.
- R7: `int_ack` while `int_req` is high sets the in-service bit of the presented level on the next clock edge and clears that level's edge latch. `int_ack` while `int_req` is low has no effect.
- R8: `int_rti` clears the highest set bit of `in_service`. In the same cycle, an acknowledge can still set its bit.
- R9: With nesting off (`cfg_nest` = 0), `int_req` stays low while any in-service bit is set.
- R10: With nesting on (`cfg_nest` = 1), a request is presented during service only if its level is strictly greater than the highest in-service level.
- R11: A configuration write (`cfg_we` = 1) loads mask, edge selection and nesting together, and they take effect from the following cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_in | input | NLINES | External request lines, bit i is level i |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_mask | input | NLINES | Mask bits to load, 1 = masked |
| cfg_edge | input | NLINES | Sensing to load, 1 = edge, 0 = level |
| cfg_nest | input | 1 | Nesting enable to load |
| int_ack | input | 1 | Core accepts the presented request |
| int_rti | input | 1 | Core returns from a service routine |
| int_req | output | 1 | A request is presented |
| int_vec | output | VEC_W | Vector address of the presented level |
| in_service | output | NLINES | In-service bit per level |

## Verification
The bench uses the default parameters: NLINES = 4 and VEC_W = 16. With four lines, every ordering of pending, masked and in-service levels can occur. This includes preemption chains through all four levels and a return that has to choose among several set in-service bits. The 16-bit vector makes the zero-extension of the two-bit level number visible. A bench-side model, driven by random line toggles, configuration writes, acknowledges and returns, covers the case where an edge and an acknowledge land in the same cycle. It also covers a return and an acknowledge in the same cycle, and an acknowledge while no request is presented.

// File: rtl/vic_pkg.sv
package vic_pkg;

  // Decide whether a winning level may be presented, given the service state.
  function automatic logic preempt_ok(input logic nest_en, input logic busy,
                                      input int unsigned win_lvl,
                                      input int unsigned top_lvl);
    if (!busy) return 1'b1;
    return nest_en && (win_lvl > top_lvl);
  endfunction

endpackage

// File: rtl/vic_prio_enc.sv
module vic_prio_enc #(
  parameter int N  = 4,
  parameter int IW = 2
) (
  input  logic [N-1:0]  req,
  output logic          any,
  output logic [IW-1:0] idx,
  output logic [N-1:0]  onehot
);
  always_comb begin
    any = 1'b0;
    idx = '0;
    for (int i = 0; i < N; i++) begin
      if (req[i]) begin
        any = 1'b1;
        idx = IW'(i);
      end
    end
    onehot = any ? (N'(1) << idx) : '0;
  end
endmodule

// File: rtl/vic_line.sv
module vic_line (
  input  logic clk,
  input  logic rst_n,
  input  logic irq,
  input  logic edge_mode,
  input  logic clr,
  output logic pend
);
  logic prev_q, lat_q, rise;

  assign rise = irq & ~prev_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      lat_q  <= 1'b0;
    end else begin
      prev_q <= irq;
      lat_q  <= edge_mode & ((lat_q & ~clr) | rise);
    end
  end

  assign pend = edge_mode ? lat_q : irq;

  // R5: a latched edge survives until its own clear
  p_edge_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_mode && lat_q && !clr) |=> lat_q);
endmodule

// File: rtl/vic_svc_track.sv
module vic_svc_track #(
  parameter int N  = 4,
  parameter int IW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  set_oh,
  input  logic          rti,
  output logic [N-1:0]  isr,
  output logic          busy,
  output logic [IW-1:0] top_idx
);
  logic [N-1:0] top_oh;

  vic_prio_enc #(.N(N), .IW(IW)) u_top (
    .req(isr), .any(busy), .idx(top_idx), .onehot(top_oh)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) isr <= '0;
    else        isr <= (isr & ~(rti ? top_oh : '0)) | set_oh;
  end

  // R8: a lone return removes exactly one in-service bit
  p_rti_pops_one_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rti && set_oh == '0 && busy) |=> $countones(isr) == $past($countones(isr)) - 1);

  // R8: the cleared bit is the highest one, lower ones stay
  p_rti_keeps_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rti && set_oh == '0 && busy) |=> !isr[$past(top_idx)]);
endmodule

// File: rtl/vic_irq_ctrl.sv
module vic_irq_ctrl #(
  parameter int NLINES = 4,
  parameter int VEC_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NLINES-1:0] irq_in,
  input  logic              cfg_we,
  input  logic [NLINES-1:0] cfg_mask,
  input  logic [NLINES-1:0] cfg_edge,
  input  logic              cfg_nest,
  input  logic              int_ack,
  input  logic              int_rti,
  output logic              int_req,
  output logic [VEC_W-1:0]  int_vec,
  output logic [NLINES-1:0] in_service
);
  import vic_pkg::*;

  localparam int IW = (NLINES > 1) ? $clog2(NLINES) : 1;

  logic [NLINES-1:0] mask_q, edge_q;
  logic              nest_q;
  logic [NLINES-1:0] pend, elig, win_oh, clr_oh;
  logic              elig_any, busy, ack_fire;
  logic [IW-1:0]     win_idx, top_idx;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask_q <= '1;
      edge_q <= '0;
      nest_q <= 1'b0;
    end else if (cfg_we) begin
      mask_q <= cfg_mask;
      edge_q <= cfg_edge;
      nest_q <= cfg_nest;
    end
  end

  for (genvar g = 0; g < NLINES; g++) begin : g_line
    vic_line u_line (
      .clk(clk), .rst_n(rst_n), .irq(irq_in[g]), .edge_mode(edge_q[g]),
      .clr(clr_oh[g]), .pend(pend[g])
    );
  end

  assign elig = pend & ~mask_q;

  vic_prio_enc #(.N(NLINES), .IW(IW)) u_win (
    .req(elig), .any(elig_any), .idx(win_idx), .onehot(win_oh)
  );

  vic_svc_track #(.N(NLINES), .IW(IW)) u_svc (
    .clk(clk), .rst_n(rst_n), .set_oh(clr_oh), .rti(int_rti),
    .isr(in_service), .busy(busy), .top_idx(top_idx)
  );

  assign int_req  = elig_any &&
                    preempt_ok(nest_q, busy, int'(win_idx), int'(top_idx));
  assign ack_fire = int_ack & int_req;
  assign clr_oh   = ack_fire ? win_oh : '0;
  assign int_vec  = VEC_W'(win_idx);

  // R2: presented line is eligible and nothing above it is
  p_highest_wins_r2: assert property (@(posedge clk) disable iff (!rst_n)
    int_req |-> (elig >> win_idx) == NLINES'(1));

  // R3: a masked line is never presented
  p_mask_blocks_r3: assert property (@(posedge clk) disable iff (!rst_n)
    int_req |-> !mask_q[win_idx]);

  // R7: acknowledge marks the presented level in service
  p_ack_marks_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ack_fire |=> in_service[$past(win_idx)]);

  // R9: no presentation during service when nesting is off
  p_no_nest_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!nest_q && busy) |-> !int_req);

  // R10: during service only a strictly higher level is presented
  p_nest_higher_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (int_req && busy) |-> win_idx > top_idx);
endmodule

// File: tb/vic_irq_ctrl_test.sv
`timescale 1ns/1ps
module vic_irq_ctrl_test;
  localparam int NL = 4;
  localparam int VW = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [NL-1:0] irq_in = '0, cfg_mask = '0, cfg_edge = '0;
  logic cfg_we = 1'b0, cfg_nest = 1'b0, int_ack = 1'b0, int_rti = 1'b0;
  logic int_req;
  logic [VW-1:0] int_vec;
  logic [NL-1:0] in_service;

  int n_chk = 0, n_bad = 0;

  always #4 clk = ~clk;

  vic_irq_ctrl #(.NLINES(NL), .VEC_W(VW)) uut (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .cfg_we(cfg_we),
    .cfg_mask(cfg_mask), .cfg_edge(cfg_edge), .cfg_nest(cfg_nest),
    .int_ack(int_ack), .int_rti(int_rti), .int_req(int_req),
    .int_vec(int_vec), .in_service(in_service)
  );

  // bench model state
  logic [NL-1:0] m_mask, m_edge, m_prev, m_lat, m_isr;
  logic m_nest;

  function automatic int top_of(input logic [NL-1:0] v);
    for (int i = NL - 1; i >= 0; i--) if (v[i]) return i;
    return -1;
  endfunction

  function automatic int model_win();
    logic [NL-1:0] p;
    for (int i = 0; i < NL; i++) p[i] = m_edge[i] ? m_lat[i] : irq_in[i];
    return top_of(p & ~m_mask);
  endfunction

  function automatic logic model_req();
    int w, t;
    w = model_win();
    t = top_of(m_isr);
    if (w < 0) return 1'b0;
    if (t < 0) return 1'b1;
    return m_nest && (w > t);
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    m_mask = '1; m_edge = '0; m_nest = 1'b0;
    m_prev = '0; m_lat = '0; m_isr = '0;
  endtask

  task automatic model_clock();
    logic fire;
    int w, t;
    fire = int_ack && model_req();
    w = model_win();
    t = top_of(m_isr);
    for (int i = 0; i < NL; i++) begin
      if (m_edge[i])
        m_lat[i] = (m_lat[i] && !(fire && w == i)) || (irq_in[i] && !m_prev[i]);
      else
        m_lat[i] = 1'b0;
    end
    if (int_rti && t >= 0) m_isr[t] = 1'b0;
    if (fire) m_isr[w] = 1'b1;
    if (cfg_we) begin
      m_mask = cfg_mask; m_edge = cfg_edge; m_nest = cfg_nest;
    end
    m_prev = irq_in;
  endtask

  // compare against model, then advance one clock; inputs set by caller
  task automatic cyc(input string tag);
    logic er;
    #1;
    er = model_req();
    chk({tag, " req"}, 32'(int_req), 32'(er));
    if (er) chk({tag, " vec R6"}, 32'(int_vec), 32'(model_win()));
    chk({tag, " isr"}, 32'(in_service), 32'(m_isr));
    @(posedge clk);
    model_clock();
    @(negedge clk);
    int_ack = 1'b0; int_rti = 1'b0; cfg_we = 1'b0;
  endtask

  task automatic cfg(input logic [NL-1:0] mk, input logic [NL-1:0] ed, input logic ns);
    cfg_we = 1'b1; cfg_mask = mk; cfg_edge = ed; cfg_nest = ns;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++; n_chk++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'd5219));
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state, all masked
    irq_in = 4'hF; #1;
    chk("R1 req after reset", 32'(int_req), 0);
    chk("R1 isr after reset", 32'(in_service), 0);
    cyc("R1");
    // R11: write takes effect the next cycle
    cfg(4'h0, 4'h0, 1'b0); irq_in = 4'b0010; #1;
    chk("R11 same-cycle write", 32'(int_req), 0);
    cyc("R11");
    #1; chk("R4 level line 1", 32'(int_req), 1);
    chk("R6 vector 1", 32'(int_vec), 1);
    irq_in = 4'b1010; #1; chk("R2 highest of 3,1", 32'(int_vec), 3);
    irq_in = 4'b0000; #1; chk("R4 drop clears", 32'(int_req), 0);
    cyc("R4");
    // R5: edge latch
    cfg(4'h0, 4'b0001, 1'b0); cyc("R11");
    irq_in = 4'b0001; cyc("R5");
    irq_in = 4'b0000; #1;
    chk("R5 edge held", 32'(int_req), 1);
    chk("R6 vector 0", 32'(int_vec), 0);
    cyc("R5"); cyc("R5");
    int_ack = 1'b1; cyc("R7");
    #1; chk("R7 isr set", 32'(in_service), 1);
    chk("R5 latch cleared", 32'(int_req), 0);
    int_rti = 1'b1; cyc("R8");
    #1; chk("R8 isr cleared", 32'(in_service), 0);
    chk("R5 no repeat", 32'(int_req), 0);
    // R7: ack without request ignored
    int_ack = 1'b1; cyc("R7");
    #1; chk("R7 stray ack", 32'(in_service), 0);
    // R3: masked edge stays pending
    cfg(4'b0001, 4'b0001, 1'b0); cyc("R3");
    irq_in = 4'b0001; cyc("R3");
    irq_in = 4'b0000; #1; chk("R3 masked", 32'(int_req), 0);
    cyc("R3"); cyc("R3");
    cfg(4'h0, 4'b0001, 1'b0); cyc("R3");
    #1; chk("R3 unmask presents", 32'(int_req), 1);
    int_ack = 1'b1; cyc("R3");
    int_rti = 1'b1; cyc("R3");
    // R10: nesting on
    cfg(4'h0, 4'h0, 1'b1); irq_in = 4'b0010; cyc("R11");
    int_ack = 1'b1; cyc("R10");
    irq_in = 4'b0011; #1; chk("R10 lower blocked", 32'(int_req), 0);
    irq_in = 4'b0110; #1; chk("R10 higher preempts", 32'(int_req), 1);
    chk("R10 vector 2", 32'(int_vec), 2);
    int_ack = 1'b1; cyc("R10");
    #1; chk("R10 isr 1,2", 32'(in_service), 4'b0110);
    int_rti = 1'b1; cyc("R8");
    #1; chk("R8 top popped", 32'(in_service), 4'b0010);
    int_rti = 1'b1; cyc("R8");
    // R9: nesting off blocks all
    cfg(4'h0, 4'h0, 1'b0); irq_in = 4'b0001; cyc("R11");
    int_ack = 1'b1; cyc("R9");
    irq_in = 4'b1001; #1; chk("R9 blocked", 32'(int_req), 0);
    int_rti = 1'b1; cyc("R9");
    // random phase, checked against the model (R2)
    for (int n = 0; n < 4000; n++) begin
      for (int b = 0; b < NL; b++) if ($urandom_range(3) == 0) irq_in[b] = ~irq_in[b];
      if ($urandom_range(39) == 0)
        cfg(4'($urandom_range(15)) & 4'($urandom_range(15)), 4'($urandom_range(15)),
            1'($urandom_range(1)));
      int_ack = ($urandom_range(2) == 0);
      int_rti = ($urandom_range(5) == 0);
      cyc("R2 random");
    end
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule